// File: doc/BRIEF.md
# Inter-Processor Message Mailbox

This block carries 63-bit messages from one processor to another through an eight-entry hardware queue. Both sides reach it through a 32-bit register port with a single-cycle select/write strobe. Reads are combinational on the address.

The sending side writes the lower half of a message first. It then writes the upper half with bit 31 set, and that second write commits the whole message to the queue. Other sender registers report the queue state, record sticky overflow and underflow errors, and hold interrupt-enable bits. A lock word gives each requester one bit, so software can claim the sender port with a read-check-set sequence.

The receiving side reads the head message as two words. Bit 31 of the upper word marks a valid message, and both words read zero when the queue is empty. Any write to the upper receive word discards the head. A level interrupt tells the receiver that messages are waiting.

Top module: `ipc_mailbox`

## Requirements
- R1: Reset empties the queue and clears the lock bits, the interrupt enables and both error flags. After reset the status word reads 0x2 and irq_o is low.
- R2: A sender write to offset 0x00 holds the lower 32 bits. A sender write to 0x04 with bit 31 set pushes {data[30:0], held lower word} as one message. A write to 0x04 with bit 31 clear pushes nothing.
- R3: Receiver offset 0x08 reads the head message's lower 32 bits. Receiver offset 0x0C reads bit 31 = 1 with the head's upper 31 bits below it. Both read 0 while the queue is empty.
- R4: The queue holds 8 messages and returns them in the order they were pushed.
- R5: Any receiver write to offset 0x0C removes the head message, whatever the write data.
- R6: The sender status word at 0x10 has bit 0 = full, bit 1 = empty and bits 7:4 = entry count.
- R7: A push while the queue is full is dropped, the stored messages are unchanged, and error bit 0 (overflow) is set. The bit stays set until it is cleared.
- R8: A pop while the queue is empty changes nothing in the queue and sets error bit 1 (underflow), which is sticky.
- R9: Writing 1 to a bit of the error word at 0x14 clears that bit. Writing 0 leaves it unchanged.
- R10: irq_o is high exactly when at least one interrupt-enable bit is set and the queue is not empty. It falls in the cycle after the last message is popped.
- R11: The lock word at 0x1C stores write data bits 3:0, one per requester. It reads them back, and the upper bits read 0.
- R12: The interrupt-enable word at 0x18 stores write data bits 3:0 and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_sel_i | input | 1 | Sender port select |
| s_write_i | input | 1 | Sender write strobe (with select) |
| s_addr_i | input | 8 | Sender byte offset |
| s_wdata_i | input | 32 | Sender write data |
| s_rdata_o | output | 32 | Sender read data |
| r_sel_i | input | 1 | Receiver port select |
| r_write_i | input | 1 | Receiver write strobe (with select) |
| r_addr_i | input | 8 | Receiver byte offset |
| r_rdata_o | output | 32 | Receiver read data |
| irq_o | output | 1 | Receiver interrupt, level |

## Verification
The bench fills the queue to eight entries and then pushes a ninth. A design that wrapped its write pointer here would overwrite the oldest message, and the check of the returned order would catch it. The bench also pops an empty queue: a design that let the read pointer move would later hand out stale data and show a non-zero count. A high-word write with bit 31 clear must not enqueue, and writing zero to the error word must not clear it. The bench watches the interrupt across the last pop and across an enable toggle, since an interrupt that stays high with the queue empty, or fires while disabled, is the usual fault.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned MSG_W  = 2 * DATA_W - 1;

  localparam logic [ADDR_W-1:0] OFS_TX_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TX_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_RX_LO = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RX_HI = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ERR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_LOCK  = 8'h1C;

  localparam int unsigned ERR_OVF = 0;
  localparam int unsigned ERR_UDF = 1;
  localparam int unsigned STAT_CNT_LSB = 4;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 63,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign head_o  = mem_q[rd_ptr_q];
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign ovf_o   = push_i & full_o;
  assign udf_o   = pop_i & empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R4
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !pop_i |=> cnt_q == $past(cnt_q)); // R7
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i |=> empty_o); // R8
  AST_POP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !empty_o && !push_i |=> cnt_q == $past(cnt_q) - 1'b1); // R5
endmodule

// File: rtl/mbx_tx_regs.sv
module mbx_tx_regs
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned CNT_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              push_o,
  output logic [MSG_W-1:0]  push_data_o,
  output logic [NUM_REQ-1:0] int_en_o,
  input  logic              full_i,
  input  logic              empty_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              ovf_i,
  input  logic              udf_i
);
  logic [DATA_W-1:0]  lo_q;
  logic [NUM_REQ-1:0] ien_q, lock_q;
  logic [1:0]         err_q, err_set, err_clr;
  logic               wr, wr_lo, wr_err, wr_ien, wr_lock;

  assign wr      = sel_i & write_i;
  assign wr_lo   = wr && addr_i == OFS_TX_LO;
  assign wr_err  = wr && addr_i == OFS_ERR;
  assign wr_ien  = wr && addr_i == OFS_IEN;
  assign wr_lock = wr && addr_i == OFS_LOCK;

  // commit only when the valid flag is set in the upper word
  assign push_o      = wr && addr_i == OFS_TX_HI && wdata_i[DATA_W-1];
  assign push_data_o = {wdata_i[DATA_W-2:0], lo_q};
  assign int_en_o    = ien_q;

  assign err_set = {udf_i, ovf_i};
  assign err_clr = wr_err ? wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      ien_q  <= '0;
      lock_q <= '0;
      err_q  <= '0;
    end else begin
      if (wr_lo)   lo_q   <= wdata_i;
      if (wr_ien)  ien_q  <= wdata_i[NUM_REQ-1:0];
      if (wr_lock) lock_q <= wdata_i[NUM_REQ-1:0];
      err_q <= (err_q & ~err_clr) | err_set;   // a new event beats a clear
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_STAT: begin
        rdata_o[0] = full_i;
        rdata_o[1] = empty_i;
        rdata_o[STAT_CNT_LSB +: CNT_W] = count_i;
      end
      OFS_ERR:  rdata_o[1:0] = err_q;
      OFS_IEN:  rdata_o[NUM_REQ-1:0] = ien_q;
      OFS_LOCK: rdata_o[NUM_REQ-1:0] = lock_q;
      default:  rdata_o = '0;
    endcase
  end

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q[ERR_OVF] && !(wr_err && wdata_i[ERR_OVF]) |=> err_q[ERR_OVF]); // R7
  AST_UDF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_i |=> err_q[ERR_UDF]); // R8
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err && wdata_i[ERR_UDF] && !udf_i |=> !err_q[ERR_UDF]); // R9
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lock |=> $stable(lock_q)); // R11
endmodule

// File: rtl/mbx_rx_port.sv
module mbx_rx_port
  import mbx_pkg::*;
(
  input  logic              sel_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pop_o,
  input  logic [MSG_W-1:0]  head_i,
  input  logic              empty_i
);
  assign pop_o = sel_i & write_i & (addr_i == OFS_RX_HI);

  always_comb begin
    rdata_o = '0;
    if (!empty_i) begin
      if (addr_i == OFS_RX_LO)      rdata_o = head_i[DATA_W-1:0];
      else if (addr_i == OFS_RX_HI) rdata_o = {1'b1, head_i[MSG_W-1:DATA_W]};
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned NUM_REQ = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_sel_i,
  input  logic              s_write_i,
  input  logic [ADDR_W-1:0] s_addr_i,
  input  logic [DATA_W-1:0] s_wdata_i,
  output logic [DATA_W-1:0] s_rdata_o,
  input  logic              r_sel_i,
  input  logic              r_write_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              irq_o
);
  logic               push, pop, full, empty, ovf, udf;
  logic [MSG_W-1:0]   push_data, head;
  logic [CNT_W-1:0]   count;
  logic [NUM_REQ-1:0] int_en;

  mbx_fifo #(.DEPTH(DEPTH), .WIDTH(MSG_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_data_i(push_data), .pop_i(pop),
    .head_o(head), .full_o(full), .empty_o(empty), .count_o(count),
    .ovf_o(ovf), .udf_o(udf)
  );

  mbx_tx_regs #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni,
    .sel_i(s_sel_i), .write_i(s_write_i), .addr_i(s_addr_i), .wdata_i(s_wdata_i),
    .rdata_o(s_rdata_o), .push_o(push), .push_data_o(push_data), .int_en_o(int_en),
    .full_i(full), .empty_i(empty), .count_i(count), .ovf_i(ovf), .udf_i(udf)
  );

  mbx_rx_port u_rx (
    .sel_i(r_sel_i), .write_i(r_write_i), .addr_i(r_addr_i), .rdata_o(r_rdata_o),
    .pop_o(pop), .head_i(head), .empty_i(empty)
  );

  assign irq_o = (|int_en) & ~empty;

  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop && count == CNT_W'(1) && !push |=> !irq_o); // R10
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push && (|int_en) && !pop |=> irq_o); // R10
endmodule

// File: tb/ipc_mailbox_test.sv
module ipc_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_sel = 1'b0, s_write = 1'b0;
  logic [7:0]  s_addr = '0;
  logic [31:0] s_wdata = '0;
  logic [31:0] s_rdata;
  logic        r_sel = 1'b0, r_write = 1'b0;
  logic [7:0]  r_addr = '0;
  logic [31:0] r_rdata;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ipc_mailbox uut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_sel_i(s_sel), .s_write_i(s_write), .s_addr_i(s_addr), .s_wdata_i(s_wdata),
    .s_rdata_o(s_rdata),
    .r_sel_i(r_sel), .r_write_i(r_write), .r_addr_i(r_addr), .r_rdata_o(r_rdata),
    .irq_o(irq)
  );

  typedef struct packed {
    logic        rx;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'h10, 32'h0,          32'h2,          8'd6},  // R6 empty
    '{1'b0, 1'b1, 8'h18, 32'h1,          32'h0,          8'd12},
    '{1'b0, 1'b0, 8'h18, 32'h0,          32'h1,          8'd12}, // R12
    '{1'b0, 1'b1, 8'h00, 32'h1111_0001,  32'h0,          8'd2},
    '{1'b0, 1'b1, 8'h04, 32'h8000_00A1,  32'h0,          8'd2},
    '{1'b0, 1'b0, 8'h10, 32'h0,          32'h10,         8'd2},  // R2 one entry
    '{1'b1, 1'b0, 8'h08, 32'h0,          32'h1111_0001,  8'd3},  // R3
    '{1'b1, 1'b0, 8'h0C, 32'h0,          32'h8000_00A1,  8'd3},
    '{1'b0, 1'b1, 8'h00, 32'h2222_0002,  32'h0,          8'd2},
    '{1'b0, 1'b1, 8'h04, 32'h0000_00B2,  32'h0,          8'd2},  // bit31 clear
    '{1'b0, 1'b0, 8'h10, 32'h0,          32'h10,         8'd2},  // R2 no push
    '{1'b0, 1'b1, 8'h04, 32'h8000_00B2,  32'h0,          8'd2},
    '{1'b1, 1'b1, 8'h0C, 32'h1234_5678,  32'h0,          8'd5},  // R5 pop
    '{1'b1, 1'b0, 8'h08, 32'h0,          32'h2222_0002,  8'd4},  // R4 order
    '{1'b1, 1'b1, 8'h0C, 32'h0,          32'h0,          8'd5},
    '{1'b1, 1'b0, 8'h0C, 32'h0,          32'h0,          8'd3},  // R3 empty
    '{1'b1, 1'b1, 8'h0C, 32'h0,          32'h0,          8'd8},  // pop on empty
    '{1'b0, 1'b0, 8'h14, 32'h0,          32'h2,          8'd8},  // R8
    '{1'b0, 1'b1, 8'h14, 32'h0,          32'h0,          8'd9},
    '{1'b0, 1'b0, 8'h14, 32'h0,          32'h2,          8'd9},  // R9 zero keeps
    '{1'b0, 1'b1, 8'h14, 32'h2,          32'h0,          8'd9},
    '{1'b0, 1'b0, 8'h14, 32'h0,          32'h0,          8'd9},  // R9 clear
    '{1'b0, 1'b1, 8'h1C, 32'hFFFF_FFF5,  32'h0,          8'd11},
    '{1'b0, 1'b0, 8'h1C, 32'h0,          32'h5,          8'd11}  // R11
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic s_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); s_sel = 1'b1; s_write = 1'b1; s_addr = a; s_wdata = d;
    @(negedge clk); s_sel = 1'b0; s_write = 1'b0;
  endtask

  task automatic s_rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); s_sel = 1'b1; s_write = 1'b0; s_addr = a;
    #2 v = s_rdata; s_sel = 1'b0;
  endtask

  task automatic r_wr(input logic [7:0] a);
    @(negedge clk); r_sel = 1'b1; r_write = 1'b1; r_addr = a;
    @(negedge clk); r_sel = 1'b0; r_write = 1'b0;
  endtask

  task automatic r_rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); r_sel = 1'b1; r_write = 1'b0; r_addr = a;
    #2 v = r_rdata; r_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({31'h0, irq}, 32'h0, "R1 irq after reset");
    s_rd(8'h14, v); check(v, 32'h0, "R1 error after reset");
    s_rd(8'h1C, v); check(v, 32'h0, "R1 lock after reset");

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        if (VECS[i].rx) r_wr(VECS[i].addr);
        else            s_wr(VECS[i].addr, VECS[i].data);
      end else begin
        if (VECS[i].rx) r_rd(VECS[i].addr, v);
        else            s_rd(VECS[i].addr, v);
        check(v, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end
    end

    // R4 R6: fill to depth
    for (int i = 0; i < 8; i++) begin
      s_wr(8'h00, 32'hA000_0000 + i);
      s_wr(8'h04, 32'h8000_0100 + i);
    end
    s_rd(8'h10, v); check(v, 32'h81, "R6 full status");
    check({31'h0, irq}, 32'h1, "R10 irq with data");
    // R7 overflow
    s_wr(8'h00, 32'hDEAD_BEEF);
    s_wr(8'h04, 32'hFFFF_FFFF);
    s_rd(8'h10, v); check(v, 32'h81, "R7 count after drop");
    s_rd(8'h14, v); check(v, 32'h1, "R7 overflow flag");
    for (int i = 0; i < 8; i++) begin
      r_rd(8'h08, v); check(v, 32'hA000_0000 + i, "R4 low order");
      r_rd(8'h0C, v); check(v, 32'h8000_0100 + i, "R4 high order");
      if (i == 7) check({31'h0, irq}, 32'h1, "R10 irq before last pop");
      r_wr(8'h0C);
    end
    check({31'h0, irq}, 32'h0, "R10 irq after last pop");
    s_rd(8'h14, v); check(v, 32'h1, "R7 overflow sticky");

    // R10 enable gating
    s_wr(8'h18, 32'h0);
    s_wr(8'h00, 32'h5);
    s_wr(8'h04, 32'h8000_0006);
    check({31'h0, irq}, 32'h0, "R10 irq disabled");
    s_wr(8'h18, 32'h8);
    check({31'h0, irq}, 32'h1, "R10 irq enabled by bit 3");

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check({31'h0, irq}, 32'h0, "R1 irq after reset");
    s_rd(8'h10, v); check(v, 32'h2, "R1 status after reset");
    s_rd(8'h18, v); check(v, 32'h0, "R1 enable after reset");
    s_rd(8'h1C, v); check(v, 32'h0, "R1 lock after reset");
    s_rd(8'h14, v); check(v, 32'h0, "R1 error after reset");
    r_rd(8'h08, v); check(v, 32'h0, "R1 rx low after reset");

    finish_run();
  end
endmodule